// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block decides, each cycle, whether the instruction sitting in decode of a five-stage in-order pipeline may issue. The pipeline has no forwarding paths. A source register that an older, still-unretired instruction is going to write must therefore wait until that write has landed. The unit compares both decode source addresses with the destination address held in each downstream pipeline register. Each comparison counts only when that stage's stored write enable is set, the destination is not register 0, and the operand is actually read. Any such match holds the PC and the IF/ID register and sends an empty slot into ID/EX.

The unit also folds in the memory stall requests. When instruction memory is not ready, the front of the pipeline holds in the same way a hazard holds it. When data memory is not ready, the whole pipeline freezes and the register-file write from MEM/WB is suppressed. The comparison against MEM/WB exists for register files without write-before-read timing, and a parameter can remove it. The block is purely combinational apart from its reset override, and it sits beside the datapath registers, which it does not contain.

Top module: `ilk_stall_top`

## Requirements
- R1: When a used decode source address equals the ID/EX destination, that stage's write enable is 1, the address is nonzero and neither memory stalls, then `pc_ifid_hold`=1 and `idex_bubble`=1.
- R2: The same match against the EX/MEM destination gives the same result.
- R3: With `CHECK_WB`=1 (the default), the same match against the MEM/WB destination gives the same result. With `CHECK_WB`=0, a MEM/WB match alone gives `pc_ifid_hold`=0 and `idex_bubble`=0.
- R4: A stage whose stored write enable is 0 never causes a stall, even if its destination equals a source address.
- R5: A destination address of 0 never causes a stall.
- R6: A source whose use flag is 0 never causes a stall.
- R7: `imem_stall`=1 with `dmem_stall`=0 gives `pc_ifid_hold`=1, `idex_bubble`=1 and `back_hold`=0.
- R8: `dmem_stall`=1 gives `pc_ifid_hold`=1, `back_hold`=1, `idex_bubble`=0 and `rf_wr_en`=0, whatever the hazards are.
- R9: Out of reset with `dmem_stall`=0, `rf_wr_en` equals `memwb_we`.
- R10: While `rst`=1, `idex_bubble`=1 and `pc_ifid_hold`, `back_hold` and `rf_wr_en` are 0, whatever the other inputs are.
- R11: With no qualified match and no memory stall, `pc_ifid_hold`, `idex_bubble` and `back_hold` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used to sample the properties |
| rst | input | 1 | Synchronous active-high reset override |
| dec_rs_addr | input | 5 | First source register address in decode |
| dec_rs_used | input | 1 | First source is read by the decoded instruction |
| dec_rt_addr | input | 5 | Second source register address in decode |
| dec_rt_used | input | 1 | Second source is read by the decoded instruction |
| idex_dst | input | 5 | Destination address held in ID/EX |
| idex_we | input | 1 | Write enable held in ID/EX |
| exmem_dst | input | 5 | Destination address held in EX/MEM |
| exmem_we | input | 1 | Write enable held in EX/MEM |
| memwb_dst | input | 5 | Destination address held in MEM/WB |
| memwb_we | input | 1 | Write enable held in MEM/WB |
| imem_stall | input | 1 | Instruction memory not ready |
| dmem_stall | input | 1 | Data memory not ready |
| pc_ifid_hold | output | 1 | Hold PC and IF/ID |
| idex_bubble | output | 1 | Clear control bits entering ID/EX |
| back_hold | output | 1 | Hold ID/EX, EX/MEM and MEM/WB |
| rf_wr_en | output | 1 | Register-file write enable from MEM/WB |

## Verification
The bench sweeps every combination of source addresses, destination addresses, use flags, write enables and stall requests over a three-value address set that includes register 0. It runs the sweep on the default unit and on a copy built without the MEM/WB comparison. The sweep covers an equal address whose stage write enable is clear: a design that skipped the write-enable qualification would stall there for nothing. It also covers equal zero addresses, where a missing zero filter would lock up on every instruction that names register 0, and unused operands, where a missing use flag would stall instructions that do not read the register. A design that bubbled during a data-memory stall would drop the held instruction. One that still let `rf_wr_en` through during that stall would write the same result twice, and both show up in the freeze vectors.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int REG_AW     = 5;
    localparam int NUM_STAGES = 3;
    localparam int NUM_SRC    = 2;

    typedef logic [REG_AW-1:0] reg_addr_t;

    // One decode-stage operand read.
    typedef struct packed {
        logic      used;
        reg_addr_t addr;
    } src_rd_t;

    // Pending register write carried by a downstream pipeline register.
    typedef struct packed {
        logic      we;
        reg_addr_t addr;
    } stage_wr_t;

    // Index order of the downstream stages inside the comparison vectors.
    typedef enum logic [1:0] {
        ST_IDEX  = 2'd0,
        ST_EXMEM = 2'd1,
        ST_MEMWB = 2'd2
    } stage_e;

    typedef struct packed {
        logic front_hold;
        logic bubble;
        logic back_hold;
        logic rf_we;
    } stall_out_t;

    // A pending write blocks an operand read only if it is real and not to register 0.
    function automatic logic wr_blocks_rd(src_rd_t rd, stage_wr_t wr);
        return rd.used && wr.we && (wr.addr != '0) && (wr.addr == rd.addr);
    endfunction

endpackage

// File: rtl/ilk_src_cmp.sv
module ilk_src_cmp
    import ilk_pkg::*;
#(
    parameter int N_STG    = NUM_STAGES,
    parameter bit CHECK_WB = 1'b1
) (
    input  src_rd_t                     src,
    input  stage_wr_t [N_STG-1:0]       stages,
    output logic      [N_STG-1:0]       hits
);

    for (genvar k = 0; k < N_STG; k++) begin : g_stage
        if ((k == int'(ST_MEMWB)) && !CHECK_WB) begin : g_off
            // Write-before-read register file: the retiring write is visible already.
            assign hits[k] = 1'b0;
        end else begin : g_on
            assign hits[k] = wr_blocks_rd(src, stages[k]);
        end
    end

endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
    import ilk_pkg::*;
(
    input  logic       rst,
    input  logic       raw_hit,
    input  logic       imem_stall,
    input  logic       dmem_stall,
    input  logic       memwb_we,
    output stall_out_t ctl
);

    always_comb begin
        ctl = '0;
        if (rst) begin
            ctl.bubble = 1'b1;
        end else if (dmem_stall) begin
            // Whole pipeline frozen; the decode instruction stays, nothing retires.
            ctl.front_hold = 1'b1;
            ctl.back_hold  = 1'b1;
        end else begin
            ctl.front_hold = raw_hit | imem_stall;
            ctl.bubble     = raw_hit | imem_stall;
            ctl.rf_we      = memwb_we;
        end
    end

endmodule

// File: rtl/ilk_stall_top.sv
module ilk_stall_top
    import ilk_pkg::*;
#(
    parameter bit CHECK_WB = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_AW-1:0]   dec_rs_addr,
    input  logic                dec_rs_used,
    input  logic [REG_AW-1:0]   dec_rt_addr,
    input  logic                dec_rt_used,
    input  logic [REG_AW-1:0]   idex_dst,
    input  logic                idex_we,
    input  logic [REG_AW-1:0]   exmem_dst,
    input  logic                exmem_we,
    input  logic [REG_AW-1:0]   memwb_dst,
    input  logic                memwb_we,
    input  logic                imem_stall,
    input  logic                dmem_stall,
    output logic                pc_ifid_hold,
    output logic                idex_bubble,
    output logic                back_hold,
    output logic                rf_wr_en
);

    src_rd_t   [NUM_SRC-1:0]    srcs;
    stage_wr_t [NUM_STAGES-1:0] pend;
    logic      [NUM_STAGES-1:0] hit_m [NUM_SRC];
    logic      [NUM_SRC-1:0]    src_hit;
    stall_out_t                 ctl;

    assign srcs[0] = '{used: dec_rs_used, addr: dec_rs_addr};
    assign srcs[1] = '{used: dec_rt_used, addr: dec_rt_addr};

    assign pend[ST_IDEX]  = '{we: idex_we,  addr: idex_dst};
    assign pend[ST_EXMEM] = '{we: exmem_we, addr: exmem_dst};
    assign pend[ST_MEMWB] = '{we: memwb_we, addr: memwb_dst};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        ilk_src_cmp #(
            .N_STG    (NUM_STAGES),
            .CHECK_WB (CHECK_WB)
        ) cmp_i (
            .src    (srcs[s]),
            .stages (pend),
            .hits   (hit_m[s])
        );
        assign src_hit[s] = |hit_m[s];
    end

    ilk_ctrl ctrl_i (
        .rst        (rst),
        .raw_hit    (|src_hit),
        .imem_stall (imem_stall),
        .dmem_stall (dmem_stall),
        .memwb_we   (memwb_we),
        .ctl        (ctl)
    );

    assign pc_ifid_hold = ctl.front_hold;
    assign idex_bubble  = ctl.bubble;
    assign back_hold    = ctl.back_hold;
    assign rf_wr_en     = ctl.rf_we;

endmodule

// File: rtl/ilk_stall_chk.sv
module ilk_stall_chk
    import ilk_pkg::*;
#(
    parameter bit CHECK_WB = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] dec_rs_addr,
    input logic              dec_rs_used,
    input logic [REG_AW-1:0] dec_rt_addr,
    input logic              dec_rt_used,
    input logic [REG_AW-1:0] idex_dst,
    input logic              idex_we,
    input logic [REG_AW-1:0] exmem_dst,
    input logic              exmem_we,
    input logic [REG_AW-1:0] memwb_dst,
    input logic              memwb_we,
    input logic              imem_stall,
    input logic              dmem_stall,
    input logic              pc_ifid_hold,
    input logic              idex_bubble,
    input logic              back_hold,
    input logic              rf_wr_en
);

    logic quiet;
    assign quiet = !imem_stall && !dmem_stall;

    assert_idex_rs_stall_R1: assert property (@(posedge clk) disable iff (rst)
        (quiet && dec_rs_used && idex_we && idex_dst != '0 && idex_dst == dec_rs_addr)
        |-> (pc_ifid_hold && idex_bubble));

    assert_exmem_rt_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (quiet && dec_rt_used && exmem_we && exmem_dst != '0 && exmem_dst == dec_rt_addr)
        |-> (pc_ifid_hold && idex_bubble));

    assert_memwb_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (CHECK_WB && quiet && dec_rs_used && memwb_we && memwb_dst != '0 && memwb_dst == dec_rs_addr)
        |-> (pc_ifid_hold && idex_bubble));

    assert_unused_free_R6: assert property (@(posedge clk) disable iff (rst)
        (quiet && !dec_rs_used && !dec_rt_used) |-> (!pc_ifid_hold && !idex_bubble));

    assert_imem_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (imem_stall && !dmem_stall) |-> (pc_ifid_hold && idex_bubble && !back_hold));

    assert_dmem_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        dmem_stall |-> (pc_ifid_hold && back_hold && !idex_bubble && !rf_wr_en));

    assert_wr_pass_R9: assert property (@(posedge clk) disable iff (rst)
        !dmem_stall |-> (rf_wr_en == memwb_we));

    assert_bubble_needs_hold_R11: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> pc_ifid_hold);

endmodule

bind ilk_stall_top ilk_stall_chk #(.CHECK_WB(CHECK_WB)) chk_i (.*);

// File: tb/ilk_stall_top_tb_top.sv
module ilk_stall_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] rs, rt, d0, d1, d2;
    logic       rs_u, rt_u, we0, we1, we2, ims, dms;
    logic       h_a, b_a, bh_a, w_a, h_b, b_b, bh_b, w_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ilk_stall_top #(.CHECK_WB(1'b1)) dut_i (
        .clk(clk), .rst(rst),
        .dec_rs_addr(rs), .dec_rs_used(rs_u), .dec_rt_addr(rt), .dec_rt_used(rt_u),
        .idex_dst(d0), .idex_we(we0), .exmem_dst(d1), .exmem_we(we1),
        .memwb_dst(d2), .memwb_we(we2), .imem_stall(ims), .dmem_stall(dms),
        .pc_ifid_hold(h_a), .idex_bubble(b_a), .back_hold(bh_a), .rf_wr_en(w_a));

    ilk_stall_top #(.CHECK_WB(1'b0)) dut_nowb_i (
        .clk(clk), .rst(rst),
        .dec_rs_addr(rs), .dec_rs_used(rs_u), .dec_rt_addr(rt), .dec_rt_used(rt_u),
        .idex_dst(d0), .idex_we(we0), .exmem_dst(d1), .exmem_we(we1),
        .memwb_dst(d2), .memwb_we(we2), .imem_stall(ims), .dmem_stall(dms),
        .pc_ifid_hold(h_b), .idex_bubble(b_b), .back_hold(bh_b), .rf_wr_en(w_b));

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (rs=%0d/%0b rt=%0d/%0b dst=%0d,%0d,%0d we=%0b%0b%0b im=%0b dm=%0b)",
                     tag, what, act, exp, rs, rs_u, rt, rt_u, d0, d1, d2, we0, we1, we2, ims, dms);
        end
    endtask

    // Does pending write (dst, we) block an operand read (addr, used)?
    function automatic bit blocks(logic [4:0] a, logic u, logic [4:0] d, logic w);
        return u && w && d != 0 && d == a;
    endfunction

    function automatic bit hazard(bit wb);
        return blocks(rs, rs_u, d0, we0) || blocks(rt, rt_u, d0, we0) ||
               blocks(rs, rs_u, d1, we1) || blocks(rt, rt_u, d1, we1) ||
               (wb && (blocks(rs, rs_u, d2, we2) || blocks(rt, rt_u, d2, we2)));
    endfunction

    // Classify a vector by the requirement that decides it.
    function automatic string tag_of(bit wb);
        if (dms) return "R8";
        if (blocks(rs, rs_u, d0, we0) || blocks(rt, rt_u, d0, we0)) return "R1";
        if (blocks(rs, rs_u, d1, we1) || blocks(rt, rt_u, d1, we1)) return "R2";
        if (blocks(rs, rs_u, d2, we2) || blocks(rt, rt_u, d2, we2)) return "R3";
        if (ims) return "R7";
        if ((rs_u && ((rs == d0 && rs != 0 && !we0) || (rs == d1 && rs != 0 && !we1) || (rs == d2 && rs != 0 && !we2))) ||
            (rt_u && ((rt == d0 && rt != 0 && !we0) || (rt == d1 && rt != 0 && !we1) || (rt == d2 && rt != 0 && !we2))))
            return "R4";
        if ((rs_u && rs == 0 && (d0 == 0 || d1 == 0 || d2 == 0)) ||
            (rt_u && rt == 0 && (d0 == 0 || d1 == 0 || d2 == 0)))
            return "R5";
        if ((!rs_u && rs != 0 && (rs == d0 || rs == d1 || rs == d2)) ||
            (!rt_u && rt != 0 && (rt == d0 || rt == d1 || rt == d2)))
            return "R6";
        return "R11";
    endfunction

    task automatic check_vec();
        for (int c = 0; c < 2; c++) begin
            bit    wb  = (c == 0);
            bit    hz  = hazard(wb);
            string tg  = tag_of(wb);
            logic  eh  = dms | hz | ims;
            logic  eb  = !dms & (hz | ims);
            logic  ebh = dms;
            logic  ew  = !dms & we2;
            check(tg, wb ? "hold" : "hold(nowb)",   wb ? h_a  : h_b,  eh);
            check(tg, wb ? "bubble" : "bubble(nowb)", wb ? b_a : b_b,  eb);
            check(tg, wb ? "back" : "back(nowb)",   wb ? bh_a : bh_b, ebh);
            check(dms ? "R8" : "R9", wb ? "rfwe" : "rfwe(nowb)", wb ? w_a : w_b, ew);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset with a live hazard and a data-memory stall applied: R10.
        rst = 1'b1;
        rs = 5'd3; rs_u = 1'b1; rt = 5'd0; rt_u = 1'b0;
        d0 = 5'd3; we0 = 1'b1; d1 = 5'd0; we1 = 1'b0; d2 = 5'd7; we2 = 1'b1;
        ims = 1'b1; dms = 1'b1;
        repeat (3) @(negedge clk);
        #5;
        check("R10", "hold in reset",   h_a,  1'b0);
        check("R10", "bubble in reset", b_a,  1'b1);
        check("R10", "back in reset",   bh_a, 1'b0);
        check("R10", "rfwe in reset",   w_a,  1'b0);
        @(negedge clk);
        rst = 1'b0;

        // Directed: register 31 match in MEM/WB only, the two configurations disagree (R3).
        rs = 5'd31; rs_u = 1'b1; rt = 5'd4; rt_u = 1'b1;
        d0 = 5'd5; we0 = 1'b1; d1 = 5'd6; we1 = 1'b1; d2 = 5'd31; we2 = 1'b1;
        ims = 1'b0; dms = 1'b0;
        #5;
        check("R3", "hold wb on",   h_a, 1'b1);
        check("R3", "hold wb off",  h_b, 1'b0);
        check("R3", "bubble wb off", b_b, 1'b0);
        @(negedge clk);

        // Near-exhaustive sweep over addresses {0,1,2}.
        for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
        for (int x = 0; x < 3; x++)
        for (int y = 0; y < 3; y++)
        for (int z = 0; z < 3; z++)
        for (int u = 0; u < 4; u++)
        for (int w = 0; w < 8; w++)
        for (int s = 0; s < 4; s++) begin
            rs = 5'(a); rt = 5'(b); d0 = 5'(x); d1 = 5'(y); d2 = 5'(z);
            rs_u = u[0]; rt_u = u[1];
            we0 = w[0]; we1 = w[1]; we2 = w[2];
            ims = s[0]; dms = s[1];
            #5;
            check_vec();
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule